// File: doc/BRIEF.md
# Frame-Synced Conditional Jump Register Port

This block is the host-side serial write port that loads the software condition code of an audio DSP sequencer and computes its jump-taken flag. A host holds the active-low request line low and shifts a command byte followed by one data byte into the serial input, most significant bit first, on rising serial-clock edges. When the command matches, the data byte is parked as pending and the ready output drops. The byte becomes the active condition code only at the next leading edge of the frame clock. Ready returns high in that same cycle.

Every serial-side input is brought into the system clock domain through two-flop synchronizers, and edges are detected after them. The jump flag is a registered OR of a 9-bit AND. One operand is the vector formed by the hardware jump pin above the 8-bit soft code. The other is a 9-bit condition mask taken from the running program word. The port has two resets. Power-on reset clears everything. Soft reset clears only the transaction state and the settle counter, so the mask and the code survive it. After either reset is released, the port refuses writes until a set number of trailing frame edges has passed.

Top module: `cond_jump_port`

## Requirements
- R1: While `por_n` is low, `code` is 0x00, the mask is 0, `rdy` is high and `jump` is low.
- R2: Serial data is taken on rising `sck` edges only while `req_n` is low. The first 8 bits form the command and the next 8 bits the data, each sent MSB first.
- R3: A transaction with command 0xC4 that reaches 16 bits while `rdy` is high and the port is settled drives `rdy` low. Any other command byte leaves `rdy` high and `code` unchanged.
- R4: The pending byte is copied to `code` at the first leading frame edge after acceptance, and `rdy` rises in that same cycle. `code` never changes while `rdy` stays high or stays low.
- R5: A transaction that completes while `rdy` is low is ignored. The pending byte is not replaced.
- R6: If `req_n` rises before 16 bits have arrived, the transaction is aborted with no effect, and the next transaction starts counting from bit zero.
- R7: `jump` is high one synchronized cycle later exactly when ({jx, code[7:0]} & mask) is nonzero. The `jx` pin is mask bit 8 and `code[i]` is mask bit i.
- R8: A high `mask_we` loads `prog_mask` into the mask. Soft reset (`srst_n` low) keeps both the mask and `code`, and releases `rdy` high.
- R9: After reset release, the port ignores transactions until it has seen a set number of trailing frame edges: 3 when `master_mode` is 0, and 1 when `master_mode` is 1.
- R10: With `frm_inv` low the leading frame edge is rising. With `frm_inv` high it is falling, and the rising edge is then the trailing edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| srst_n | input | 1 | Soft reset, active low, synchronous |
| master_mode | input | 1 | Selects the master-mode settle count |
| frm_inv | input | 1 | Inverts the frame-clock polarity |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| req_n | input | 1 | Active-low transaction request |
| frm | input | 1 | Frame clock |
| jx | input | 1 | Hardware jump condition pin |
| prog_mask | input | 9 | Condition mask from the program word |
| mask_we | input | 1 | Loads `prog_mask` into the mask register |
| rdy | output | 1 | High when the port can accept a write |
| jump | output | 1 | Registered jump-taken flag |
| code | output | 8 | Active soft condition code |

## Verification
The hardest situations to reach are a second write arriving while a first one is still pending, and a write landing inside the settle window that follows a reset. Neither shows up at the ports unless the frame clock is held still at the right moment. The bench therefore drives the frame clock one edge at a time. It issues the competing write before releasing the commit edge, and it counts trailing edges after each reset, placing a write just one edge short of the limit. With the frame polarity inverted, the bench checks the output after the rising edge alone, which shows that only the falling edge commits.

// File: rtl/cond_jump_port.sv
module cond_jump_port #(
  parameter int          DW            = 8,
  parameter logic [7:0]  CMD           = 8'hC4,
  parameter int          SLAVE_FRAMES  = 3,
  parameter int          MASTER_FRAMES = 1
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          srst_n,
  input  logic          master_mode,
  input  logic          frm_inv,
  input  logic          sck,
  input  logic          sdi,
  input  logic          req_n,
  input  logic          frm,
  input  logic          jx,
  input  logic [DW:0]   prog_mask,
  input  logic          mask_we,
  output logic          rdy,
  output logic          jump,
  output logic [DW-1:0] code
);
  localparam int FW   = 2 * DW;
  localparam int BCW  = $clog2(FW + 1);
  localparam int SMAX = (SLAVE_FRAMES > MASTER_FRAMES) ? SLAVE_FRAMES : MASTER_FRAMES;
  localparam int SCW  = $clog2(SMAX + 1);

  logic [2:0] sck_q, frm_q, req_q;
  logic [1:0] sdi_q, jx_q;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      sck_q <= '0;
      frm_q <= '0;
      req_q <= '1;
      sdi_q <= '0;
      jx_q  <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sck};
      frm_q <= {frm_q[1:0], frm};
      req_q <= {req_q[1:0], req_n};
      sdi_q <= {sdi_q[0], sdi};
      jx_q  <= {jx_q[0], jx};
    end

  wire sck_rise = sck_q[1] & ~sck_q[2];
  wire frm_rise = frm_q[1] & ~frm_q[2];
  wire frm_fall = ~frm_q[1] & frm_q[2];
  wire lead     = frm_inv ? frm_fall : frm_rise;
  wire trail    = frm_inv ? frm_rise : frm_fall;
  wire req_act  = ~req_q[1];

  logic [FW-1:0]  sh;
  logic [BCW-1:0] bcnt;
  logic [SCW-1:0] scnt;
  logic [DW-1:0]  pend;
  logic [DW:0]    mask;

  wire [SCW-1:0] target  = master_mode ? SCW'(MASTER_FRAMES) : SCW'(SLAVE_FRAMES);
  wire           settled = (scnt >= target);
  wire [FW-1:0]  word    = {sh[FW-2:0], sdi_q[1]};
  wire           last    = req_act && sck_rise && (bcnt == BCW'(FW - 1));
  wire           accept  = last && (word[FW-1:DW] == CMD) && rdy && settled;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      sh   <= '0;
      bcnt <= '0;
    end else if (!srst_n || !req_act) begin
      bcnt <= '0;
    end else if (sck_rise && bcnt < BCW'(FW)) begin
      sh   <= word;
      bcnt <= bcnt + 1'b1;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                  scnt <= '0;
    else if (!srst_n)            scnt <= '0;
    else if (trail && !settled)  scnt <= scnt + 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      code <= '0;
      pend <= '0;
      rdy  <= 1'b1;
    end else if (!srst_n) begin
      rdy  <= 1'b1;
    end else if (!rdy && lead) begin
      code <= pend;
      rdy  <= 1'b1;
    end else if (accept) begin
      pend <= word[DW-1:0];
      rdy  <= 1'b0;
    end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)       mask <= '0;
    else if (mask_we) mask <= prog_mask;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) jump <= 1'b0;
    else        jump <= |({jx_q[1], code} & mask);

endmodule

module cond_jump_port_chk #(parameter int DW = 8) (
  input logic          clk,
  input logic          por_n,
  input logic          srst_n,
  input logic          rdy,
  input logic          jump,
  input logic [DW-1:0] code,
  input logic [DW-1:0] pend,
  input logic [DW:0]   mask,
  input logic          mask_we,
  input logic          settled
);
  assert_por_clear_R1: assert property (@(posedge clk)
    !por_n |=> (code == '0 && rdy && !jump && mask == '0));

  assert_code_hold_R4: assert property (@(posedge clk) disable iff (!por_n)
    (rdy == $past(rdy)) |-> $stable(code));

  assert_commit_value_R4: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(rdy) && $past(srst_n)) |-> code == $past(pend));

  assert_busy_needs_settle_R9: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rdy) |-> $past(settled));

  assert_mask_kept_R8: assert property (@(posedge clk) disable iff (!por_n)
    !$past(mask_we) |-> $stable(mask));

  assert_no_mask_no_jump_R7: assert property (@(posedge clk) disable iff (!por_n)
    (mask == '0) |=> !jump);
endmodule

bind cond_jump_port cond_jump_port_chk #(.DW(DW)) u_chk (
  .clk(clk), .por_n(por_n), .srst_n(srst_n), .rdy(rdy), .jump(jump),
  .code(code), .pend(pend), .mask(mask), .mask_we(mask_we), .settled(settled)
);

// File: tb/tb_cond_jump_port.sv
module tb_cond_jump_port;
  logic clk = 0, por_n = 0, srst_n = 1, master_mode = 0, frm_inv = 0;
  logic sck = 0, sdi = 0, req_n = 1, frm = 0, jx = 0, mask_we = 0;
  logic [8:0] prog_mask = '0;
  logic rdy, jump;
  logic [7:0] code;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  cond_jump_port dut (.clk, .por_n, .srst_n, .master_mode, .frm_inv, .sck, .sdi,
    .req_n, .frm, .jx, .prog_mask, .mask_we, .rdy, .jump, .code);

  task automatic chk(input string tag, input logic [8:0] got, input logic [8:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] w, input int nbits);
    req_n = 0; wclk(4);
    for (int i = 15; i > 15 - nbits; i--) begin
      sdi = w[i]; wclk(3); sck = 1; wclk(3); sck = 0;
    end
    wclk(3); req_n = 1; wclk(8);
  endtask

  task automatic write(input logic [7:0] c, input logic [7:0] d);
    send_bits({c, d}, 16);
  endtask

  task automatic frm_to(input logic v);
    frm = v; wclk(8);
  endtask

  task automatic pulse;
    frm_to(1); frm_to(0);
  endtask

  task automatic set_mask(input logic [8:0] m);
    prog_mask = m; mask_we = 1; wclk(1); mask_we = 0; wclk(6);
  endtask

  task automatic t_reset;
    wclk(3);
    chk("R1 rdy in reset", rdy, 1);
    chk("R1 code in reset", code, 0);
    chk("R1 jump in reset", jump, 0);
    por_n = 1; wclk(4);
  endtask

  task automatic t_settle_por;
    write(8'hC4, 8'h77);
    chk("R9 write before settle ignored", rdy, 1);
    pulse(); pulse();
    write(8'hC4, 8'h66);
    chk("R9 two trailing edges not enough", rdy, 1);
    pulse();
    chk("R9 code untouched", code, 0);
    write(8'hC4, 8'hA5);
    chk("R3 accepted write drops rdy", rdy, 0);
    chk("R4 code unchanged before frame", code, 0);
    frm_to(1);
    chk("R4 commit on rising frame edge", code, 9'h0A5);
    chk("R4 rdy back high", rdy, 1);
    frm_to(0);
  endtask

  task automatic t_bad_cmd;
    write(8'hC5, 8'h3C);
    chk("R3 other command keeps rdy", rdy, 1);
    pulse();
    chk("R3 other command keeps code", code, 9'h0A5);
  endtask

  task automatic t_abort;
    send_bits({8'hC4, 8'h99}, 10);
    chk("R6 aborted write keeps rdy", rdy, 1);
    pulse();
    chk("R6 aborted write keeps code", code, 9'h0A5);
    write(8'hC4, 8'h5A);
    chk("R6 next write counts from zero", rdy, 0);
    pulse();
    chk("R2 MSB-first data 5A", code, 9'h05A);
  endtask

  task automatic t_busy;
    write(8'hC4, 8'h11);
    write(8'hC4, 8'h22);
    chk("R5 still busy", rdy, 0);
    pulse();
    chk("R5 first byte kept", code, 9'h011);
    write(8'hC4, 8'h01);
    pulse();
    chk("R2 LSB-only data 01", code, 9'h001);
  endtask

  task automatic t_jump;
    set_mask(9'h100); jx = 1; wclk(6);
    chk("R7 pin bit 8 match", jump, 1);
    jx = 0; wclk(6);
    chk("R7 pin low no match", jump, 0);
    set_mask(9'h001);
    chk("R7 code bit 0 match", jump, 1);
    set_mask(9'h0FE);
    chk("R7 disjoint bits", jump, 0);
    set_mask(9'h000); jx = 1; wclk(6);
    chk("R7 zero mask", jump, 0);
    jx = 0;
  endtask

  task automatic t_soft_reset;
    set_mask(9'h003);
    chk("R8 mask loaded", jump, 1);
    master_mode = 1;
    srst_n = 0; wclk(4); srst_n = 1; wclk(6);
    chk("R8 code kept over soft reset", code, 9'h001);
    chk("R8 mask kept over soft reset", jump, 1);
    write(8'hC4, 8'h0F);
    chk("R9 master write before settle ignored", rdy, 1);
    pulse();
    write(8'hC4, 8'h0F);
    chk("R9 master settles after one edge", rdy, 0);
    pulse();
    chk("R4 commit after master settle", code, 9'h00F);
  endtask

  task automatic t_inverted;
    frm_inv = 1;
    write(8'hC4, 8'hC3);
    frm_to(1);
    chk("R10 rising edge is trailing", rdy, 0);
    chk("R10 no commit on rise", code, 9'h00F);
    frm_to(0);
    chk("R10 commit on falling edge", code, 9'h0C3);
    chk("R10 rdy high after commit", rdy, 1);
  endtask

  initial begin
    t_reset();
    t_settle_por();
    t_bad_cmd();
    t_abort();
    t_busy();
    t_jump();
    t_soft_reset();
    t_inverted();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule